// File: doc/BRIEF.md
# SCL Clock-Stretch Timeout Monitor

This block runs beside an I2C master engine. It watches the clock line during the part of each bit where the master has stopped driving SCL low and expects it to rise. A slave may hold SCL low during that time to stretch the clock. The monitor counts how long the stretch lasts in SCL-period ticks. If the count reaches a programmed 16-bit limit, the slave is judged unresponsive. The monitor then sends a one-cycle abort request to the master engine and raises a sticky timeout status bit. Software clears that bit by writing one to it.

A limit of zero turns detection off. The count restarts whenever SCL is seen high while released, and whenever the master takes SCL back. This means each stretch is timed on its own. After a timeout the monitor stays quiet until the master drops the release request. That ends the current transfer.

The controller has four states:
- `MON_IDLE`: SCL is not released, or detection is off.
- `MON_STRETCH`: SCL is released but still low; ticks are counted.
- `MON_HIGH`: SCL is released and seen high; the count is held at zero.
- `MON_EXPIRED`: the limit was reached; the monitor waits for the release to drop.

The transitions are:
- IDLE→STRETCH: release with SCL low and a non-zero limit.
- IDLE→HIGH: release with SCL high and a non-zero limit.
- STRETCH→HIGH: SCL rises.
- HIGH→STRETCH: SCL falls while still released.
- STRETCH→EXPIRED: the counting tick brings the count to the limit.
- STRETCH/HIGH→IDLE: the release drops or the limit becomes zero.
- EXPIRED→IDLE: the release drops.

Top module: `scl_stretch_monitor`

## Requirements
- R1: A tick is counted only when `scl_release`=1, `scl_level`=0 and `scl_tick`=1 all hold at a clock edge, and the monitor is in the stretch state. The monitor enters that state one edge after the release is seen with SCL low. With limit L, `abort_req` is 1 in the cycle after the edge that counted the L-th tick.
- R2: `timeout_flag` becomes 1 in the same cycle as the `abort_req` pulse.
- R3: When `stretch_limit` is 0, no count takes place and `abort_req` never rises, whatever ticks arrive.
- R4: `timeout_flag` is sticky. A one-cycle `status_clear`=1 drops it to 0 after the next edge. If a timeout and a clear meet at the same edge, the flag stays 1.
- R5: `abort_req` is high for exactly one clock cycle per timeout.
- R6: After a timeout, further ticks produce no abort until `scl_release` has dropped and risen again.
- R7: Seeing SCL high while released resets the count to zero, so a later low period starts counting from zero.
- R8: Ticks while `scl_release`=0 are ignored, and dropping the release resets the count.
- R9: After reset, `timeout_flag`=0 and `abort_req`=0.
- R10: The boundary limits work: limit 1 times out on the first counted tick, and limit 16'hFFFF times out on the 65535th tick and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_release | input | 1 | Master has released SCL and expects it high |
| scl_level | input | 1 | Synchronised SCL level |
| scl_tick | input | 1 | One-cycle pulse per SCL period |
| stretch_limit | input | LIMIT_W | Timeout limit in SCL periods; 0 disables |
| status_clear | input | 1 | Write-one-to-clear pulse for the timeout bit |
| timeout_flag | output | 1 | Sticky timeout status bit |
| abort_req | output | 1 | One-cycle abort request to the master engine |

## Verification
The bench builds the monitor with the default `LIMIT_W` of 16, so the full 16-bit range of the limit can be reached. Small limits of 1 and 3 make the exact tick on which the abort fires easy to observe, together with the resets caused by SCL rising and by the release dropping. A limit of 16'hFFFF, with the tick held high every cycle, runs the counter to its top value. This shows that no wrap or early compare fires before the 65535th tick.

// File: rtl/stretch_mon_pkg.sv
package stretch_mon_pkg;
    typedef enum logic [1:0] {
        MON_IDLE    = 2'd0,
        MON_STRETCH = 2'd1,
        MON_HIGH    = 2'd2,
        MON_EXPIRED = 2'd3
    } mon_state_t;
endpackage

// File: rtl/stretch_counter.sv
module stretch_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         step,
    output logic [W-1:0] count,
    output logic [W-1:0] count_inc
);
    assign count_inc = count + W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (step) begin
            count <= count_inc;
        end
    end

    // count restarts from zero after any clear (SCL high, release drop)
    assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0));
endmodule

// File: rtl/sticky_bit.sv
module sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clear,
    output logic q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (set) begin
            q <= 1'b1;
        end else if (clear) begin
            q <= 1'b0;
        end
    end

    assert_flag_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q && !clear) |=> q);
    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> q);
endmodule

// File: rtl/scl_stretch_monitor.sv
module scl_stretch_monitor
    import stretch_mon_pkg::*;
#(
    parameter int LIMIT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_release,
    input  logic               scl_level,
    input  logic               scl_tick,
    input  logic [LIMIT_W-1:0] stretch_limit,
    input  logic               status_clear,
    output logic               timeout_flag,
    output logic               abort_req
);
    localparam logic [LIMIT_W-1:0] LIMIT_OFF = '0;

    mon_state_t         state_q, state_d;
    logic               enabled;
    logic               cnt_clear, cnt_step, hit;
    logic [LIMIT_W-1:0] cnt, cnt_inc;

    assign enabled   = (stretch_limit != LIMIT_OFF);
    assign cnt_step  = (state_q == MON_STRETCH) && enabled && scl_release
                       && !scl_level && scl_tick;
    assign cnt_clear = (state_q != MON_STRETCH) || !enabled || !scl_release
                       || scl_level;
    assign hit       = cnt_step && (cnt_inc == stretch_limit);

    stretch_counter #(.W(LIMIT_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (cnt_clear),
        .step      (cnt_step),
        .count     (cnt),
        .count_inc (cnt_inc)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MON_IDLE: begin
                if (scl_release && enabled)
                    state_d = scl_level ? MON_HIGH : MON_STRETCH;
            end
            MON_STRETCH: begin
                if (!scl_release || !enabled) state_d = MON_IDLE;
                else if (scl_level)           state_d = MON_HIGH;
                else if (hit)                 state_d = MON_EXPIRED;
            end
            MON_HIGH: begin
                if (!scl_release || !enabled) state_d = MON_IDLE;
                else if (!scl_level)          state_d = MON_STRETCH;
            end
            MON_EXPIRED: begin
                if (!scl_release) state_d = MON_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MON_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) abort_req <= 1'b0;
        else        abort_req <= hit;
    end

    sticky_bit u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (hit),
        .clear (status_clear),
        .q     (timeout_flag)
    );

    assert_abort_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |-> $past(scl_release && !scl_level && scl_tick));
    assert_abort_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |-> timeout_flag);
    assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stretch_limit == LIMIT_OFF) |=> !abort_req);
    assert_abort_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |=> !abort_req);
    assert_expired_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == MON_EXPIRED) && $past(state_q == MON_EXPIRED)) |-> !abort_req);
endmodule

// File: tb/tb_scl_stretch_monitor.sv
module tb_scl_stretch_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_release = 1'b0;
    logic        scl_level = 1'b0;
    logic        scl_tick = 1'b0;
    logic [15:0] stretch_limit = 16'd0;
    logic        status_clear = 1'b0;
    logic        timeout_flag, abort_req;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    scl_stretch_monitor #(.LIMIT_W(16)) dut (
        .clk(clk), .rst_n(rst_n), .scl_release(scl_release), .scl_level(scl_level),
        .scl_tick(scl_tick), .stretch_limit(stretch_limit), .status_clear(status_clear),
        .timeout_flag(timeout_flag), .abort_req(abort_req)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // drive lines, then allow one edge for the monitor to change state
    task automatic set_lines(input logic rel, input logic lvl);
        @(negedge clk);
        scl_release = rel;
        scl_level = lvl;
        @(negedge clk);
    endtask

    // one tick pulse; returns abort as seen after the edge that took it
    task automatic tick(output logic ab);
        @(negedge clk);
        scl_tick = 1'b1;
        @(negedge clk);
        ab = abort_req;
        scl_tick = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk);
        status_clear = 1'b1;
        @(negedge clk);
        status_clear = 1'b0;
    endtask

    task automatic idle_all();
        set_lines(1'b0, 1'b1);
        clear_flag();
    endtask

    task automatic t_reset();
        check("R9", "flag after reset", int'(timeout_flag), 0);
        check("R9", "abort after reset", int'(abort_req), 0);
    endtask

    task automatic t_basic();
        logic ab;
        int early = 0;
        stretch_limit = 16'd3;
        set_lines(1'b1, 1'b0);
        for (int i = 0; i < 2; i++) begin
            tick(ab);
            if (ab) early++;
        end
        check("R1", "abort before limit", early, 0);
        check("R2", "flag before limit", int'(timeout_flag), 0);
        tick(ab);
        check("R1", "abort on third tick", int'(ab), 1);
        check("R2", "flag with abort", int'(timeout_flag), 1);
        @(negedge clk);
        check("R5", "abort one cycle only", int'(abort_req), 0);
    endtask

    task automatic t_after_timeout();
        logic ab;
        int extra = 0;
        for (int i = 0; i < 5; i++) begin
            tick(ab);
            if (ab) extra++;
        end
        check("R6", "aborts after timeout", extra, 0);
        set_lines(1'b0, 1'b0);
        check("R4", "flag sticky after release", int'(timeout_flag), 1);
        clear_flag();
        check("R4", "flag cleared", int'(timeout_flag), 0);
        set_lines(1'b1, 1'b0);
        tick(ab); tick(ab);
        tick(ab);
        check("R6", "abort again after re-release", int'(ab), 1);
    endtask

    task automatic t_disabled();
        logic ab;
        int seen = 0;
        idle_all();
        stretch_limit = 16'd0;
        set_lines(1'b1, 1'b0);
        for (int i = 0; i < 20; i++) begin
            tick(ab);
            if (ab) seen++;
        end
        check("R3", "aborts with limit 0", seen, 0);
        check("R3", "flag with limit 0", int'(timeout_flag), 0);
    endtask

    task automatic t_high_resets();
        logic ab;
        int seen = 0;
        idle_all();
        stretch_limit = 16'd3;
        set_lines(1'b1, 1'b0);
        tick(ab); if (ab) seen++;
        tick(ab); if (ab) seen++;
        set_lines(1'b1, 1'b1);
        set_lines(1'b1, 1'b0);
        tick(ab); if (ab) seen++;
        tick(ab); if (ab) seen++;
        check("R7", "no abort after SCL high reset", seen, 0);
        tick(ab);
        check("R7", "abort on third tick after reset", int'(ab), 1);
    endtask

    task automatic t_release_low();
        logic ab;
        int seen = 0;
        idle_all();
        stretch_limit = 16'd3;
        for (int i = 0; i < 6; i++) begin
            tick(ab);
            if (ab) seen++;
        end
        check("R8", "ticks while not released", seen, 0);
        set_lines(1'b1, 1'b0);
        tick(ab); if (ab) seen++;
        tick(ab); if (ab) seen++;
        set_lines(1'b0, 1'b0);
        set_lines(1'b1, 1'b0);
        tick(ab); if (ab) seen++;
        tick(ab); if (ab) seen++;
        check("R8", "release drop restarts count", seen, 0);
        tick(ab);
        check("R8", "abort after fresh count", int'(ab), 1);
    endtask

    task automatic t_set_wins();
        logic ab;
        idle_all();
        stretch_limit = 16'd1;
        set_lines(1'b1, 1'b0);
        @(negedge clk);
        scl_tick = 1'b1;
        status_clear = 1'b1;
        @(negedge clk);
        ab = abort_req;
        scl_tick = 1'b0;
        status_clear = 1'b0;
        check("R10", "limit 1 aborts on first tick", int'(ab), 1);
        check("R4", "set wins over clear", int'(timeout_flag), 1);
    endtask

    task automatic t_max_limit();
        int early = 0;
        idle_all();
        stretch_limit = 16'hFFFF;
        set_lines(1'b1, 1'b0);
        @(negedge clk);
        scl_tick = 1'b1;
        for (int k = 1; k < 65535; k++) begin
            @(negedge clk);
            if (abort_req) early++;
        end
        check("R10", "early abort at max limit", early, 0);
        @(negedge clk);
        check("R10", "abort at 65535th tick", int'(abort_req), 1);
        scl_tick = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_basic();
        t_after_timeout();
        t_disabled();
        t_high_resets();
        t_release_low();
        t_set_wins();
        t_max_limit();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule